// File: doc/BRIEF.md
# Converter Fault Supervisor

This block is the protection state machine of a switching regulator. It decides, once per clock, whether the power stage may switch. Its inputs are two undervoltage comparator flags, one for the bias supply and one for the conversion input. It also reads a digital die temperature code, a feedback code and the present soft-start level. When any fault appears, it leaves the run state. It then drops the run enable and holds the soft-start node discharged and the compensation node clamped until it is allowed to restart.

Recovery depends on which fault was seen:

- **Undervoltage:** the block waits only for both supply flags to clear.
- **Short circuit:** the block waits for exactly one hiccup timeout, then tries again.
- **Over-temperature:** the timeout is restarted every time it runs out while the die is still hot. The block restarts only at a timeout that ends after the die has cooled.

The present state and the most recent fault cause are brought out as status codes.

Top module: `conv_fault_supervisor`

## Requirements
- R1: While `rst` is high the block is in state HOLD (code 1) with cause NONE (code 0) and `run_en` low. With no fault present, the first clock edge after reset is released moves it to RUN (code 0).
- R2: `run_en` is 1 exactly when the state is RUN. `ss_discharge` and `comp_clamp` are always the inverse of `run_en`, so leaving idle raises run and releases both in the same cycle.
- R3: In RUN, a clock edge that sees `uv_bias` or `uv_input` high moves the block to HOLD with cause UV (code 1).
- R4: In HOLD the block stays put as long as either undervoltage flag is high. On the first edge at which both are low and the die is not hot, it moves to RUN, with no timer involved. The cause code keeps its last fault value while in RUN.
- R5: An internal hot flag is set on the edge after `temp_code` >= 145, cleared on the edge after `temp_code` <= 135, and held for codes from 136 to 144.
- R6: In RUN, a set hot flag with no undervoltage moves the block to HICCUP (code 2) with cause THERM (code 2). The timer is loaded.
- R7: The reference in use is the lower of `ss_level` and 800. A short exists when `fb_code` + 250 is below that reference (1 LSB = 1 mV). While in RUN, one clock edge that sees a short, with no undervoltage and no heat, moves the block to HICCUP with cause SHORT (code 3).
- R8: A hiccup whose cause is SHORT lasts exactly `HICCUP_CYCLES` cycles. If no fault is present at its end, the block returns to RUN.
- R9: When a hiccup timeout ends while the hot flag is set, the timer reloads and the block stays in HICCUP. RUN comes only at a timeout end with the hot flag clear.
- R10: Priority is undervoltage over thermal over short. An undervoltage during HICCUP goes to HOLD with cause UV. Heat during a short hiccup changes the cause to THERM without restarting the running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_bias | input | 1 | Bias supply below its threshold |
| uv_input | input | 1 | Conversion input below its threshold |
| temp_code | input | TEMP_W | Die temperature, 1 LSB = 1 degree C |
| fb_code | input | FB_W | Feedback voltage, 1 LSB = 1 mV |
| ss_level | input | FB_W | Present soft-start level, 1 LSB = 1 mV |
| run_en | output | 1 | Gate drivers may switch |
| ss_discharge | output | 1 | Pull the soft-start node low |
| comp_clamp | output | 1 | Pull the compensation node low |
| state_o | output | 2 | 0 RUN, 1 HOLD, 2 HICCUP |
| cause_o | output | 2 | 0 NONE, 1 UV, 2 THERM, 3 SHORT |

## Verification
The bench builds the block with `HICCUP_CYCLES` = 8 and keeps the default thresholds (145/135 degrees, 800 mV reference, 250 mV margin). The short timeout brings the exact hiccup length into reach within a few dozen cycles. It also makes it cheap to hold the die hot across one expiry and observe a hiccup of exactly two timeouts. The default codes let the bench probe the trip and release temperatures one code on either side. They also let it probe the short margin exactly at 250 mV, under both the fixed reference and a low soft-start level.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_HICCUP = 2'd2
    } sup_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_UV    = 2'd1,
        CAUSE_THERM = 2'd2,
        CAUSE_SHORT = 2'd3
    } cause_e;

    typedef struct packed {
        logic uv;
        logic hot;
        logic short_ckt;
    } fault_vec_t;

    // Highest-ranked fault present: undervoltage, then heat, then short.
    function automatic cause_e fault_rank(fault_vec_t f);
        if (f.uv)             return CAUSE_UV;
        else if (f.hot)       return CAUSE_THERM;
        else if (f.short_ckt) return CAUSE_SHORT;
        else                  return CAUSE_NONE;
    endfunction

    function automatic logic is_idle(sup_state_e s);
        return s != ST_RUN;
    endfunction

endpackage

// File: rtl/fsup_thermal.sv
module fsup_thermal #(
    parameter int TEMP_W     = 8,
    parameter int TRIP_CODE  = 145,
    parameter int CLEAR_CODE = 135
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot
);
    localparam logic [TEMP_W-1:0] TRIP_T  = TEMP_W'(TRIP_CODE);
    localparam logic [TEMP_W-1:0] CLEAR_T = TEMP_W'(CLEAR_CODE);

    always_ff @(posedge clk) begin
        if (rst)                     hot <= 1'b0;
        else if (temp_code >= TRIP_T)  hot <= 1'b1;
        else if (temp_code <= CLEAR_T) hot <= 1'b0;
    end

    p_hot_set_r5: assert property (@(posedge clk) disable iff (rst)
        (temp_code >= TRIP_T) |=> hot);
    p_hot_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (temp_code <= CLEAR_T) |=> !hot);
    p_hot_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (temp_code > CLEAR_T && temp_code < TRIP_T) |=> (hot == $past(hot)));

endmodule

// File: rtl/fsup_short_det.sv
module fsup_short_det #(
    parameter int FB_W      = 10,
    parameter int VREF_CODE = 800,
    parameter int SC_MARGIN = 250
) (
    input  logic [FB_W-1:0] fb_code,
    input  logic [FB_W-1:0] ss_level,
    output logic            short_ckt
);
    localparam logic [FB_W-1:0] VREF_C   = FB_W'(VREF_CODE);
    localparam logic [FB_W:0]   MARGIN_C = (FB_W+1)'(SC_MARGIN);

    logic [FB_W-1:0] ref_active;
    logic [FB_W:0]   fb_plus;

    always_comb begin
        ref_active = (ss_level < VREF_C) ? ss_level : VREF_C;
        fb_plus    = {1'b0, fb_code} + MARGIN_C;
        short_ckt  = fb_plus < {1'b0, ref_active};
    end

endmodule

// File: rtl/fsup_hiccup_timer.sv
module fsup_hiccup_timer #(
    parameter int HICCUP_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic en,
    output logic expired
);
    localparam int CNT_W = (HICCUP_CYCLES > 1) ? $clog2(HICCUP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HICCUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= LOAD_V;
        else if (en && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == LOAD_V));
    p_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor
    import fsup_pkg::*;
#(
    parameter int TEMP_W        = 8,
    parameter int TRIP_CODE     = 145,
    parameter int CLEAR_CODE    = 135,
    parameter int FB_W          = 10,
    parameter int VREF_CODE     = 800,
    parameter int SC_MARGIN     = 250,
    parameter int HICCUP_CYCLES = 20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_bias,
    input  logic              uv_input,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [FB_W-1:0]   fb_code,
    input  logic [FB_W-1:0]   ss_level,
    output logic              run_en,
    output logic              ss_discharge,
    output logic              comp_clamp,
    output logic [1:0]        state_o,
    output logic [1:0]        cause_o
);
    sup_state_e state, nxt_state;
    cause_e     cause, nxt_cause;
    fault_vec_t flt;
    logic       hot, sc, tmr_load, tmr_done;

    fsup_thermal #(
        .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE), .CLEAR_CODE(CLEAR_CODE)
    ) i_thermal (
        .clk(clk), .rst(rst), .temp_code(temp_code), .hot(hot)
    );

    fsup_short_det #(
        .FB_W(FB_W), .VREF_CODE(VREF_CODE), .SC_MARGIN(SC_MARGIN)
    ) i_short (
        .fb_code(fb_code), .ss_level(ss_level), .short_ckt(sc)
    );

    fsup_hiccup_timer #(
        .HICCUP_CYCLES(HICCUP_CYCLES)
    ) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load),
        .en(state == ST_HICCUP), .expired(tmr_done)
    );

    always_comb begin
        flt.uv        = uv_bias | uv_input;
        flt.hot       = hot;
        flt.short_ckt = sc;
    end

    always_comb begin
        nxt_state = state;
        nxt_cause = cause;
        tmr_load  = 1'b0;
        unique case (state)
            ST_RUN: begin
                unique case (fault_rank(flt))
                    CAUSE_UV: begin
                        nxt_state = ST_HOLD;
                        nxt_cause = CAUSE_UV;
                    end
                    CAUSE_THERM: begin
                        nxt_state = ST_HICCUP;
                        nxt_cause = CAUSE_THERM;
                        tmr_load  = 1'b1;
                    end
                    CAUSE_SHORT: begin
                        nxt_state = ST_HICCUP;
                        nxt_cause = CAUSE_SHORT;
                        tmr_load  = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_HOLD: begin
                if (flt.uv) begin
                    nxt_cause = CAUSE_UV;
                end else if (flt.hot) begin
                    nxt_state = ST_HICCUP;
                    nxt_cause = CAUSE_THERM;
                    tmr_load  = 1'b1;
                end else begin
                    nxt_state = ST_RUN;
                end
            end
            ST_HICCUP: begin
                if (flt.uv) begin
                    nxt_state = ST_HOLD;
                    nxt_cause = CAUSE_UV;
                end else begin
                    if (flt.hot) nxt_cause = CAUSE_THERM;
                    if (tmr_done) begin
                        if (flt.hot) tmr_load  = 1'b1;
                        else         nxt_state = ST_RUN;
                    end
                end
            end
            default: nxt_state = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            cause <= CAUSE_NONE;
        end else begin
            state <= nxt_state;
            cause <= nxt_cause;
        end
    end

    always_comb begin
        run_en       = !is_idle(state);
        ss_discharge = is_idle(state);
        comp_clamp   = is_idle(state);
        state_o      = state;
        cause_o      = cause;
    end

    p_uv_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && (uv_bias || uv_input)) |=> (state == ST_HOLD && cause == CAUSE_UV));
    p_uv_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && (uv_bias || uv_input)) |=> (state == ST_HOLD));
    p_therm_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && hot && !uv_bias && !uv_input) |=> (state == ST_HICCUP && cause == CAUSE_THERM));
    p_short_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && sc && !hot && !uv_bias && !uv_input) |=> (state == ST_HICCUP && cause == CAUSE_SHORT));
    p_hiccup_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HICCUP && !tmr_done) |=> (state != ST_RUN));
    p_therm_recycle_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HICCUP && tmr_done && hot && !uv_bias && !uv_input) |=> (state == ST_HICCUP));
    p_uv_preempt_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HICCUP && (uv_bias || uv_input)) |=> (state == ST_HOLD && cause == CAUSE_UV));
    p_run_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> ($past(state) != ST_RUN && !ss_discharge && !comp_clamp));

endmodule

// File: tb/test_conv_fault_supervisor.sv
module test_conv_fault_supervisor;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv_bias = 1'b0, uv_input = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic [9:0] fb_code = 10'd800, ss_level = 10'd1000;
    logic       run_en, ss_discharge, comp_clamp;
    logic [1:0] state_o, cause_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    conv_fault_supervisor #(.HICCUP_CYCLES(N)) i_conv_fault_supervisor (
        .clk(clk), .rst(rst), .uv_bias(uv_bias), .uv_input(uv_input),
        .temp_code(temp_code), .fb_code(fb_code), .ss_level(ss_level),
        .run_en(run_en), .ss_discharge(ss_discharge), .comp_clamp(comp_clamp),
        .state_o(state_o), .cause_o(cause_o)
    );

    typedef struct packed {
        logic [7:0] req;
        logic       uvb;
        logic       uvi;
        logic [7:0] temp;
        logic [9:0] fb;
        logic [9:0] ss;
        logic [7:0] wt;
        logic       exp_run;
        logic [1:0] exp_st;
        logic [1:0] exp_cause;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{8'd1,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd4,  1'b1, 2'd0, 2'd0}, // R1
        '{8'd3,  1'b1, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd3,  1'b0, 2'd1, 2'd1}, // R3
        '{8'd4,  1'b1, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd20, 1'b0, 2'd1, 2'd1}, // R4
        '{8'd4,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd2,  1'b1, 2'd0, 2'd1}, // R4
        '{8'd3,  1'b0, 1'b1, 8'd25,  10'd800, 10'd1000, 8'd3,  1'b0, 2'd1, 2'd1}, // R3
        '{8'd4,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd2,  1'b1, 2'd0, 2'd1}, // R4
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd550, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd1}, // R7
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd549, 10'd1000, 8'd3,  1'b0, 2'd2, 2'd3}, // R7
        '{8'd8,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd3}, // R8
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd50,  10'd300,  8'd20, 1'b1, 2'd0, 2'd3}, // R7
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd49,  10'd300,  8'd3,  1'b0, 2'd2, 2'd3}, // R7
        '{8'd8,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd3}, // R8
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd560, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd3}, // R7
        '{8'd5,  1'b0, 1'b0, 8'd144, 10'd800, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd3}, // R5
        '{8'd6,  1'b0, 1'b0, 8'd145, 10'd800, 10'd1000, 8'd3,  1'b0, 2'd2, 2'd2}, // R6
        '{8'd9,  1'b0, 1'b0, 8'd140, 10'd800, 10'd1000, 8'd30, 1'b0, 2'd2, 2'd2}, // R9
        '{8'd5,  1'b0, 1'b0, 8'd136, 10'd800, 10'd1000, 8'd30, 1'b0, 2'd2, 2'd2}, // R5
        '{8'd9,  1'b0, 1'b0, 8'd135, 10'd800, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd2}, // R9
        '{8'd10, 1'b1, 1'b0, 8'd150, 10'd800, 10'd1000, 8'd5,  1'b0, 2'd1, 2'd1}, // R10
        '{8'd10, 1'b0, 1'b0, 8'd150, 10'd800, 10'd1000, 8'd3,  1'b0, 2'd2, 2'd2}, // R10
        '{8'd9,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd20, 1'b1, 2'd0, 2'd2}, // R9
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd500, 10'd1000, 8'd3,  1'b0, 2'd2, 2'd3}, // R7
        '{8'd10, 1'b0, 1'b0, 8'd150, 10'd500, 10'd1000, 8'd3,  1'b0, 2'd2, 2'd2}, // R10
        '{8'd9,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd24, 1'b1, 2'd0, 2'd2}, // R9
        '{8'd7,  1'b0, 1'b0, 8'd25,  10'd500, 10'd1000, 8'd3,  1'b0, 2'd2, 2'd3}, // R7
        '{8'd10, 1'b0, 1'b1, 8'd25,  10'd500, 10'd1000, 8'd2,  1'b0, 2'd1, 2'd1}, // R10
        '{8'd4,  1'b0, 1'b0, 8'd25,  10'd800, 10'd1000, 8'd2,  1'b1, 2'd0, 2'd1}  // R4
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle_pins(input string req);
        check({req, " discharge"}, int'(ss_discharge), int'(!run_en));
        check({req, " clamp"}, int'(comp_clamp), int'(!run_en));
    endtask

    // Count negedge samples spent in HICCUP (state is already HICCUP at entry).
    task automatic count_hiccup(output int n, input int cool_at);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            if (n == cool_at) temp_code = 8'd25;
            @(negedge clk);
            if (state_o != 2'd2) break;
            n++;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 state", int'(state_o), 1);
        check("R1 cause", int'(cause_o), 0);
        check("R1 run", int'(run_en), 0);
        check_idle_pins("R2 reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            uv_bias   = VECS[i].uvb;
            uv_input  = VECS[i].uvi;
            temp_code = VECS[i].temp;
            fb_code   = VECS[i].fb;
            ss_level  = VECS[i].ss;
            repeat (int'(VECS[i].wt)) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d run v%0d", VECS[i].req, i), int'(run_en), int'(VECS[i].exp_run));
            check($sformatf("R%0d state v%0d", VECS[i].req, i), int'(state_o), int'(VECS[i].exp_st));
            check($sformatf("R%0d cause v%0d", VECS[i].req, i), int'(cause_o), int'(VECS[i].exp_cause));
            check_idle_pins("R2");
        end

        // R7 / R8: short enters after one edge, hiccup lasts exactly N cycles
        fb_code = 10'd500;
        @(negedge clk);
        check("R7 short latency", int'(state_o), 2);
        fb_code = 10'd800;
        count_hiccup(n, -1);
        check("R8 short hiccup length", n, N);
        check("R8 run after hiccup", int'(run_en), 1);

        // R5 / R6: thermal needs two edges (hot flag registered)
        repeat (3) @(negedge clk);
        temp_code = 8'd150;
        @(negedge clk);
        check("R5 flag latency", int'(state_o), 0);
        @(negedge clk);
        check("R6 thermal entry", int'(state_o), 2);
        // R9: hot across the first expiry -> exactly two timeouts
        count_hiccup(n, N + 2);
        check("R9 recycled hiccup length", n, 2 * N);
        check("R9 run after cool", int'(run_en), 1);

        // R9: cooled well before the first expiry -> one timeout
        repeat (3) @(negedge clk);
        temp_code = 8'd150;
        repeat (2) @(negedge clk);
        count_hiccup(n, 1);
        check("R9 single hiccup length", n, N);

        // R1: reset mid-fault clears the cause and forces HOLD
        uv_bias = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset state", int'(state_o), 1);
        check("R1 reset cause", int'(cause_o), 0);
        uv_bias = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 run after reset", int'(run_en), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule